// File: doc/BRIEF.md
# Local Descriptor Selector Store Unit

This unit executes the system instruction that copies the current local descriptor table selector (a 16-bit value) into a general-purpose register or into memory. Each cycle in which `in_valid` is high, it takes the instruction bytes, the processor mode, the privilege level, the user-mode-instruction-prevention control bit and the alignment-check enable. It also takes the attributes of the memory operand's segment, the effective address and the selector. It decodes and checks this input. One cycle later it presents exactly one outcome: a register write, a 16-bit memory write, a single fault code, or, for bytes that do not encode this instruction, no action at all.

A register destination always receives the selector zero-extended to 64 bits, and the reported width tells the register file how many bits to update. A memory destination is always a 16-bit store, whatever the operand size. Address translation, page walks and descriptor loading happen elsewhere. The unit takes in only their results: limit, writability, the null flag and canonical status.

Top module: `ldtsel_store_unit`

## Requirements
- R1: The instruction matches only when `op_byte0` is 0x0F, `op_byte1` is 0x00 and bits [5:3] of `modrm` are 0. For any other bytes, `out_valid` rises with `insn_match` low, no write enable and `fault_code` 0.
- R2: If `modrm[7:6]` is 3, the destination is a register and `reg_data` is the selector zero-extended to 64 bits. `reg_width` equals `opnd_size` (0=16, 1=32, 2=64; value 3 is reported as 2). `reg_idx` is `{rex_b, modrm[2:0]}` in 64-bit mode and `{0, modrm[2:0]}` in other modes.
- R3: For a memory destination, `mem_we` is high, `mem_data` is the 16-bit selector and `mem_addr` is the effective address. The operand size has no effect.
- R4: `cpu_mode` is encoded 0=real, 1=virtual-8086, 2=protected, 3=compatibility, 4=64-bit. Modes 0, 1 and 5 to 7 give `fault_code` 1 (invalid opcode).
- R5: A LOCK prefix gives `fault_code` 1.
- R6: With `umip` set and `cpl` not 0, `fault_code` is 2 (general protection, error code 0).
- R7: These checks apply in modes 2 and 3 for a memory destination. `seg_id` is encoded 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. A 16-bit access is over the limit when `eff_addr`+1 > `seg_limit`. `fault_code` is 2 if the segment is not writable, if `seg_null` is set for ES, DS, FS or GS, or if the access is over the limit through any segment other than SS. If none of those holds and an access through SS is over the limit, `fault_code` is 3 (stack fault).
- R8: In mode 4, a memory destination with `addr_canonical` low gives `fault_code` 3 through SS and 2 through any other segment. No limit, null or writability checks apply in this mode.
- R9: A memory destination with `ac_en` set, `cpl` equal to 3 and `eff_addr[0]` set gives `fault_code` 4 (alignment).
- R10: Only one fault is reported. The order is: code 1 first, then the privilege-based code 2, then segment or canonical faults, then code 4.
- R11: When `fault_code` is nonzero, `reg_we` and `mem_we` are low. Whenever an enable is low, its data, address, width and index outputs are 0.
- R12: All outputs are registered one cycle after `in_valid`. `out_valid` follows `in_valid` with that one-cycle delay. A synchronous active-low reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| lock_pfx | input | 1 | LOCK prefix present |
| rex_b | input | 1 | Register extension bit (64-bit mode) |
| cpu_mode | input | 3 | Processor mode |
| cpl | input | 2 | Current privilege level |
| umip | input | 1 | User-mode instruction prevention control |
| ac_en | input | 1 | Alignment checking enabled |
| opnd_size | input | 2 | Register operand size |
| seg_id | input | 3 | Segment of memory operand |
| seg_writable | input | 1 | Segment is writable |
| seg_null | input | 1 | Segment register holds null selector |
| seg_limit | input | 32 | Segment limit |
| eff_addr | input | 32 | Effective address |
| addr_canonical | input | 1 | Address is canonical (64-bit mode) |
| ldt_sel | input | 16 | Current local descriptor table selector |
| out_valid | output | 1 | Result valid |
| insn_match | output | 1 | Bytes encoded this instruction |
| reg_we | output | 1 | Register write enable |
| reg_idx | output | 4 | Destination register index |
| reg_width | output | 2 | Register write width |
| reg_data | output | 64 | Register write value |
| mem_we | output | 1 | Memory write enable (16-bit) |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 16 | Memory write value |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 alignment |

## Verification
Every outcome is due on the first rising edge after the strobe. The bench drives an input on a falling edge and samples every output on the next falling edge, half a period after the capturing edge. The expected outcome is computed from the requirements when the stimulus is applied, and is compared at that sample point. An idle cycle between strobes confirms that `out_valid` drops one edge after `in_valid` does.

// File: rtl/ldtsel_pkg.sv
package ldtsel_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int REG_W  = 64;

  typedef enum logic [2:0] {
    MD_REAL = 3'd0, MD_V86 = 3'd1, MD_PROT = 3'd2, MD_COMPAT = 3'd3, MD_LONG = 3'd4
  } cpu_mode_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_UD = 3'd1, FLT_GP = 3'd2, FLT_SS = 3'd3, FLT_AC = 3'd4
  } fault_e;

  localparam logic [2:0] SEG_ES = 3'd0;
  localparam logic [2:0] SEG_CS = 3'd1;
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;
  localparam logic [2:0] SEG_FS = 3'd4;
  localparam logic [2:0] SEG_GS = 3'd5;

  // Selector placed in the low bits of a full-width register, rest cleared
  function automatic logic [REG_W-1:0] widen_sel(input logic [SEL_W-1:0] s);
    return {{(REG_W-SEL_W){1'b0}}, s};
  endfunction

  // Two-byte store ends past the limit when its last byte exceeds it
  function automatic logic beyond_limit(input logic [ADDR_W-1:0] ea,
                                        input logic [ADDR_W-1:0] lim);
    logic [ADDR_W:0] last;
    last = {1'b0, ea} + {{ADDR_W{1'b0}}, 1'b1};
    return last > {1'b0, lim};
  endfunction

  // Segments whose null selector is a fault when used for data access
  function automatic logic null_checked(input logic [2:0] seg);
    return (seg == SEG_DS) || (seg == SEG_ES) || (seg == SEG_FS) || (seg == SEG_GS);
  endfunction
endpackage

// File: rtl/ldtsel_decode.sv
module ldtsel_decode
  import ldtsel_pkg::*;
(
  input  logic [7:0] op_byte0,
  input  logic [7:0] op_byte1,
  input  logic [7:0] modrm,
  input  logic       lock_pfx,
  input  logic [2:0] cpu_mode,
  output logic       match,
  output logic       is_reg,
  output logic       bad_mode,
  output logic       ud_hit
);
  always_comb begin
    match    = (op_byte0 == 8'h0F) && (op_byte1 == 8'h00) && (modrm[5:3] == 3'd0);
    is_reg   = (modrm[7:6] == 2'b11);
    bad_mode = !((cpu_mode == MD_PROT) || (cpu_mode == MD_COMPAT) || (cpu_mode == MD_LONG));
    ud_hit   = match && (lock_pfx || bad_mode);
  end
endmodule

// File: rtl/ldtsel_fault_chk.sv
module ldtsel_fault_chk
  import ldtsel_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          match,
  input  logic          ud_hit,
  input  logic          is_reg,
  input  logic [2:0]    cpu_mode,
  input  logic [1:0]    cpl,
  input  logic          umip,
  input  logic          ac_en,
  input  logic [2:0]    seg_id,
  input  logic          seg_writable,
  input  logic          seg_null,
  input  logic [AW-1:0] seg_limit,
  input  logic [AW-1:0] eff_addr,
  input  logic          addr_canonical,
  output logic          umip_hit,
  output logic          seg_gp_hit,
  output logic          seg_ss_hit,
  output logic          ac_hit,
  output fault_e        fault
);
  logic mem_dst, long_md, over;

  always_comb begin
    mem_dst  = match && !is_reg;
    long_md  = (cpu_mode == MD_LONG);
    over     = beyond_limit(eff_addr, seg_limit);
    umip_hit = match && umip && (cpl != 2'd0);
    if (long_md) begin
      seg_gp_hit = mem_dst && !addr_canonical && (seg_id != SEG_SS);
      seg_ss_hit = mem_dst && !addr_canonical && (seg_id == SEG_SS);
    end else begin
      seg_gp_hit = mem_dst && (!seg_writable || (seg_null && null_checked(seg_id))
                               || (over && (seg_id != SEG_SS)));
      seg_ss_hit = mem_dst && over && (seg_id == SEG_SS);
    end
    ac_hit = mem_dst && ac_en && (cpl == 2'd3) && eff_addr[0];

    if      (ud_hit)     fault = FLT_UD;
    else if (umip_hit)   fault = FLT_GP;
    else if (seg_gp_hit) fault = FLT_GP;
    else if (seg_ss_hit) fault = FLT_SS;
    else if (ac_hit)     fault = FLT_AC;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/ldtsel_result.sv
module ldtsel_result
  import ldtsel_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic             match,
  input  logic             is_reg,
  input  fault_e           fault,
  input  logic [7:0]       modrm,
  input  logic             rex_b,
  input  logic [2:0]       cpu_mode,
  input  logic [1:0]       opnd_size,
  input  logic [AW-1:0]    eff_addr,
  input  logic [SEL_W-1:0] ldt_sel,
  output logic             reg_we,
  output logic [3:0]       reg_idx,
  output logic [1:0]       reg_width,
  output logic [REG_W-1:0] reg_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [SEL_W-1:0] mem_data
);
  logic clean;

  always_comb begin
    clean     = match && (fault == FLT_NONE);
    reg_we    = clean && is_reg;
    mem_we    = clean && !is_reg;
    reg_idx   = '0;
    reg_width = '0;
    reg_data  = '0;
    mem_addr  = '0;
    mem_data  = '0;
    if (reg_we) begin
      reg_idx   = {rex_b && (cpu_mode == MD_LONG), modrm[2:0]};
      reg_width = (opnd_size == 2'd3) ? 2'd2 : opnd_size;
      reg_data  = widen_sel(ldt_sel);
    end
    if (mem_we) begin
      mem_addr = eff_addr;
      mem_data = ldt_sel;
    end
  end
endmodule

// File: rtl/ldtsel_store_unit.sv
module ldtsel_store_unit
  import ldtsel_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       op_byte0,
  input  logic [7:0]       op_byte1,
  input  logic [7:0]       modrm,
  input  logic             lock_pfx,
  input  logic             rex_b,
  input  logic [2:0]       cpu_mode,
  input  logic [1:0]       cpl,
  input  logic             umip,
  input  logic             ac_en,
  input  logic [1:0]       opnd_size,
  input  logic [2:0]       seg_id,
  input  logic             seg_writable,
  input  logic             seg_null,
  input  logic [AW-1:0]    seg_limit,
  input  logic [AW-1:0]    eff_addr,
  input  logic             addr_canonical,
  input  logic [SEL_W-1:0] ldt_sel,
  output logic             out_valid,
  output logic             insn_match,
  output logic             reg_we,
  output logic [3:0]       reg_idx,
  output logic [1:0]       reg_width,
  output logic [REG_W-1:0] reg_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [SEL_W-1:0] mem_data,
  output logic [2:0]       fault_code
);
  logic             match_w, is_reg_w, bad_mode_w, ud_w;
  logic             umip_w, seg_gp_w, seg_ss_w, ac_w;
  fault_e           fault_w;
  logic             reg_we_w, mem_we_w;
  logic [3:0]       reg_idx_w;
  logic [1:0]       reg_width_w;
  logic [REG_W-1:0] reg_data_w;
  logic [AW-1:0]    mem_addr_w;
  logic [SEL_W-1:0] mem_data_w;

  ldtsel_decode u_dec (
    .op_byte0(op_byte0), .op_byte1(op_byte1), .modrm(modrm), .lock_pfx(lock_pfx),
    .cpu_mode(cpu_mode), .match(match_w), .is_reg(is_reg_w), .bad_mode(bad_mode_w),
    .ud_hit(ud_w)
  );

  ldtsel_fault_chk #(.AW(AW)) u_flt (
    .match(match_w), .ud_hit(ud_w), .is_reg(is_reg_w), .cpu_mode(cpu_mode), .cpl(cpl),
    .umip(umip), .ac_en(ac_en), .seg_id(seg_id), .seg_writable(seg_writable),
    .seg_null(seg_null), .seg_limit(seg_limit), .eff_addr(eff_addr),
    .addr_canonical(addr_canonical), .umip_hit(umip_w), .seg_gp_hit(seg_gp_w),
    .seg_ss_hit(seg_ss_w), .ac_hit(ac_w), .fault(fault_w)
  );

  ldtsel_result #(.AW(AW)) u_res (
    .match(match_w), .is_reg(is_reg_w), .fault(fault_w), .modrm(modrm), .rex_b(rex_b),
    .cpu_mode(cpu_mode), .opnd_size(opnd_size), .eff_addr(eff_addr), .ldt_sel(ldt_sel),
    .reg_we(reg_we_w), .reg_idx(reg_idx_w), .reg_width(reg_width_w), .reg_data(reg_data_w),
    .mem_we(mem_we_w), .mem_addr(mem_addr_w), .mem_data(mem_data_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      out_valid  <= 1'b0;
      insn_match <= 1'b0;
      reg_we     <= 1'b0;
      reg_idx    <= '0;
      reg_width  <= '0;
      reg_data   <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_data   <= '0;
      fault_code <= FLT_NONE;
    end else begin
      out_valid  <= 1'b1;
      insn_match <= match_w;
      reg_we     <= reg_we_w;
      reg_idx    <= reg_idx_w;
      reg_width  <= reg_width_w;
      reg_data   <= reg_data_w;
      mem_we     <= mem_we_w;
      mem_addr   <= mem_addr_w;
      mem_data   <= mem_data_w;
      fault_code <= fault_w;
    end
  end

  AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R12
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0) |-> (!reg_we && !mem_we)); // R11
  AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, mem_we, fault_code != 3'd0})); // R11
  AST_REG_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && reg_we_w |=> reg_data == {{(REG_W-SEL_W){1'b0}}, $past(ldt_sel)}); // R2
  AST_MEM_SEL16: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mem_we_w |=> mem_data == $past(ldt_sel)); // R3
  AST_LOCK_UD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && match_w && lock_pfx |=> fault_code == 3'd1); // R5
  AST_MODE_UD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && match_w && bad_mode_w |=> fault_code == 3'd1); // R4
  AST_UMIP_GP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && umip_w && !ud_w |=> fault_code == 3'd2); // R6
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !match_w |=> !reg_we && !mem_we && fault_code == 3'd0); // R1
endmodule

// File: tb/sim_ldtsel_store_unit.sv
module sim_ldtsel_store_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 0;
  logic [7:0]  op_byte0 = 0, op_byte1 = 0, modrm = 0;
  logic        lock_pfx = 0, rex_b = 0, umip = 0, ac_en = 0;
  logic [2:0]  cpu_mode = 0, seg_id = 0;
  logic [1:0]  cpl = 0, opnd_size = 0;
  logic        seg_writable = 1, seg_null = 0, addr_canonical = 1;
  logic [31:0] seg_limit = 0, eff_addr = 0;
  logic [15:0] ldt_sel = 0;

  logic        out_valid, insn_match, reg_we, mem_we;
  logic [3:0]  reg_idx;
  logic [1:0]  reg_width;
  logic [63:0] reg_data;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic [2:0]  fault_code;

  ldtsel_store_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_byte0(op_byte0), .op_byte1(op_byte1),
    .modrm(modrm), .lock_pfx(lock_pfx), .rex_b(rex_b), .cpu_mode(cpu_mode), .cpl(cpl),
    .umip(umip), .ac_en(ac_en), .opnd_size(opnd_size), .seg_id(seg_id),
    .seg_writable(seg_writable), .seg_null(seg_null), .seg_limit(seg_limit),
    .eff_addr(eff_addr), .addr_canonical(addr_canonical), .ldt_sel(ldt_sel),
    .out_valid(out_valid), .insn_match(insn_match), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_width(reg_width), .reg_data(reg_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .fault_code(fault_code)
  );

  int n_chk = 0, n_fail = 0;
  string force_tag = "";

  logic        e_match, e_rwe, e_mwe;
  logic [3:0]  e_idx;
  logic [1:0]  e_wid;
  logic [63:0] e_rdata;
  logic [31:0] e_maddr;
  logic [15:0] e_mdata;
  logic [2:0]  e_flt;
  string       e_tag;

  // Segment-class fault from the requirements (R7, R8): 0 none, 2 GP, 3 SS
  function automatic logic [2:0] seg_fault_of();
    logic [32:0] last_b;
    if (cpu_mode == 3'd4)
      return addr_canonical ? 3'd0 : ((seg_id == 3'd2) ? 3'd3 : 3'd2);
    last_b = {1'b0, eff_addr} + 33'd1;
    if (!seg_writable) return 3'd2;
    if (seg_null && seg_id != 3'd1 && seg_id != 3'd2) return 3'd2;
    if (last_b > {1'b0, seg_limit}) return (seg_id == 3'd2) ? 3'd3 : 3'd2;
    return 3'd0;
  endfunction

  task automatic model();
    logic isreg, okmode;
    logic [2:0] sf;
    e_match = (op_byte0 == 8'h0F) && (op_byte1 == 8'h00) && (modrm[5:3] == 3'd0);
    isreg   = (modrm[7:6] == 2'b11);
    okmode  = (cpu_mode == 3'd2) || (cpu_mode == 3'd3) || (cpu_mode == 3'd4);
    e_rwe = 0; e_mwe = 0; e_idx = 0; e_wid = 0; e_rdata = 0; e_maddr = 0; e_mdata = 0;
    e_flt = 0;
    if (!e_match) e_tag = "R1";
    else if (lock_pfx) begin e_flt = 1; e_tag = "R5"; end
    else if (!okmode) begin e_flt = 1; e_tag = "R4"; end
    else if (umip && cpl != 0) begin e_flt = 2; e_tag = "R6"; end
    else if (isreg) begin
      e_rwe = 1; e_rdata = {48'd0, ldt_sel}; e_wid = (opnd_size == 3) ? 2'd2 : opnd_size;
      e_idx = {rex_b && cpu_mode == 3'd4, modrm[2:0]}; e_tag = "R2";
    end else begin
      sf = seg_fault_of();
      if (sf != 0) begin e_flt = sf; e_tag = (cpu_mode == 3'd4) ? "R8" : "R7"; end
      else if (ac_en && cpl == 3 && eff_addr[0]) begin e_flt = 4; e_tag = "R9"; end
      else begin e_mwe = 1; e_maddr = eff_addr; e_mdata = ldt_sel; e_tag = "R3"; end
    end
    if (e_flt != 0 && (e_rwe || e_mwe)) e_tag = "R11";
    if (force_tag != "") e_tag = force_tag;
  endtask

  task automatic step();
    model();
    in_valid = 1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b1 || insn_match !== e_match || reg_we !== e_rwe || mem_we !== e_mwe ||
        reg_idx !== e_idx || reg_width !== e_wid || reg_data !== e_rdata ||
        mem_addr !== e_maddr || mem_data !== e_mdata || fault_code !== e_flt) begin
      n_fail++;
      $display("FAIL %s: act v=%0b m=%0b rwe=%0b mwe=%0b idx=%0h w=%0d rd=%h ma=%h md=%h f=%0d exp v=1 m=%0b rwe=%0b mwe=%0b idx=%0h w=%0d rd=%h ma=%h md=%h f=%0d",
        e_tag, out_valid, insn_match, reg_we, mem_we, reg_idx, reg_width, reg_data, mem_addr,
        mem_data, fault_code, e_match, e_rwe, e_mwe, e_idx, e_wid, e_rdata, e_maddr, e_mdata,
        e_flt);
    end
    force_tag = "";
  endtask

  task automatic base(input logic [2:0] md, input logic [7:0] rm);
    op_byte0 = 8'h0F; op_byte1 = 8'h00; modrm = rm; lock_pfx = 0; rex_b = 0;
    cpu_mode = md; cpl = 0; umip = 0; ac_en = 0; opnd_size = 1; seg_id = 3;
    seg_writable = 1; seg_null = 0; seg_limit = 32'h0000_FFFF; eff_addr = 32'h100;
    addr_canonical = 1; ldt_sel = 16'hA5C3;
  endtask

  task automatic randomize_in();
    op_byte0 = ($urandom % 10 != 0) ? 8'h0F : 8'($urandom);
    op_byte1 = ($urandom % 10 != 0) ? 8'h00 : 8'($urandom);
    modrm = 8'($urandom);
    if ($urandom % 7 != 0) modrm[5:3] = 3'd0;
    lock_pfx = ($urandom % 10 == 0);
    rex_b = 1'($urandom);
    cpu_mode = ($urandom % 5 == 0) ? 3'($urandom) : 3'(2 + $urandom % 3);
    cpl = 2'($urandom);
    umip = ($urandom % 4 == 0);
    ac_en = 1'($urandom);
    opnd_size = 2'($urandom);
    seg_id = 3'($urandom % 6);
    seg_writable = ($urandom % 8 != 0);
    seg_null = ($urandom % 10 == 0);
    seg_limit = ($urandom % 2) ? 32'($urandom % 1024) : $urandom;
    eff_addr = ($urandom % 3 == 0) ? seg_limit - 32'($urandom % 3) : 32'($urandom % 2048);
    addr_canonical = ($urandom % 6 != 0);
    ldt_sel = 16'($urandom);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h0005_EED5);
    repeat (3) @(negedge clk);
    n_chk++;  // R12: reset state
    if (out_valid !== 0 || reg_we !== 0 || mem_we !== 0 || fault_code !== 0 || reg_data !== 0) begin
      n_fail++;
      $display("FAIL R12: reset act v=%0b rwe=%0b mwe=%0b f=%0d exp all 0",
               out_valid, reg_we, mem_we, fault_code);
    end
    rst_n = 1;

    base(3'd2, 8'hC3); opnd_size = 2; step();                   // R2 64-bit zero extension
    base(3'd4, 8'hC5); rex_b = 1; opnd_size = 1; step();        // R2 extended index
    base(3'd2, 8'h06); opnd_size = 2; step();                   // R3 memory stays 16 bits
    base(3'd2, 8'hC0); op_byte1 = 8'h01; step();                // R1 wrong byte
    base(3'd2, 8'hC8); step();                                  // R1 reg field 1
    base(3'd0, 8'hC0); step();                                  // R4 real mode
    base(3'd1, 8'h06); step();                                  // R4 virtual-8086
    base(3'd3, 8'hC0); lock_pfx = 1; step();                    // R5
    base(3'd2, 8'hC0); umip = 1; cpl = 1; step();               // R6
    base(3'd2, 8'h06); seg_limit = 32'h100; eff_addr = 32'hFF; step(); // R7 fits exactly
    base(3'd2, 8'h06); seg_limit = 32'h100; eff_addr = 32'h100; step(); // R7 last byte over
    base(3'd3, 8'h06); seg_id = 2; seg_limit = 32'h10; eff_addr = 32'h10; step(); // R7 SS
    base(3'd2, 8'h06); seg_id = 1; seg_null = 1; step();        // R7 CS null not checked
    base(3'd2, 8'h06); seg_id = 4; seg_null = 1; step();        // R7 FS null
    base(3'd4, 8'h06); seg_id = 2; addr_canonical = 0; step();  // R8 SS
    base(3'd4, 8'h06); addr_canonical = 0; step();              // R8 GP
    base(3'd4, 8'h06); seg_limit = 0; seg_writable = 0; step(); // R8 no limit checks
    base(3'd2, 8'h06); ac_en = 1; cpl = 3; eff_addr = 32'h101; step(); // R9
    base(3'd2, 8'h06); ac_en = 1; cpl = 3; eff_addr = 32'h101; umip = 1; seg_writable = 0;
    force_tag = "R10"; step();                                  // R10 UMIP wins
    base(3'd1, 8'h06); umip = 1; cpl = 3; force_tag = "R10"; step(); // R10 UD wins
    base(3'd2, 8'h06); ac_en = 1; cpl = 3; eff_addr = 32'h101; seg_limit = 0;
    force_tag = "R10"; step();                                  // R10 segment before AC
    base(3'd2, 8'hC1); cpl = 3; umip = 1; force_tag = "R11"; step(); // R11 reg write held

    in_valid = 0;
    @(negedge clk);
    n_chk++;  // R12: out_valid drops one edge after strobe drops
    if (out_valid !== 0 || reg_we !== 0 || mem_we !== 0) begin
      n_fail++;
      $display("FAIL R12: idle act v=%0b rwe=%0b mwe=%0b exp 0 0 0", out_valid, reg_we, mem_we);
    end

    for (int i = 0; i < 400; i++) begin
      randomize_in();
      step();
      if (i % 50 == 49) begin
        in_valid = 0;
        @(negedge clk);
        n_chk++;  // R12
        if (out_valid !== 0) begin
          n_fail++;
          $display("FAIL R12: gap act v=%0b exp 0", out_valid);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R12: watchdog expired act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule